// File: doc/BRIEF.md
# Channel-List ADC Sequencer

This block is the register-side controller of a multiplexed analog-to-digital front end. Software loads a queue of 8-bit conversion descriptors. Each descriptor names an input channel, a gain step, a polarity and a single-ended or differential input. Software then picks how conversions are started: not at all, by reading the start address, by a periodic scan tick, or by an edge on an external trigger pin. For every conversion the sequencer takes the next descriptor and drives it onto the mux, gain, polarity and differential outputs. It then pulses a start request to the converter, waits for the converter's done pulse, and pushes the 12-bit code into a result queue. Software drains that queue through a data address.

A 16-bit register bus gives access to two write-only control words, a status word, an interrupt-clear strobe and the shared descriptor/result address. The result code is stored exactly as the converter delivers it. Software turns it into straight binary by inverting bit 11. Each queue is emptied, and held empty, while its enable bit is clear.

In one-pass operation each descriptor is consumed when its conversion completes. In continuous operation the descriptors are kept, and the sequencer walks them cyclically, returning to the first after the last. A pending-event word and an interrupt line report a result queue that reaches half full and accepted external triggers.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the status word reads 0x0004 (result queue empty, nothing else set), conv_start_o and irq_o are low, and all front-end select outputs are zero.
- R2: While a conversion runs, mux_sel_o, gain_o, unipolar_o and diff_o carry bits [3:0], [5:4], 6 and 7 of that conversion's descriptor. They change only in the cycle where conv_start_o is raised.
- R3: With control word A bits [1:0] = 1 (software start), a bus read of address 0x00 starts exactly one conversion. In any other start mode such a read starts nothing. conv_start_o is a one-cycle pulse.
- R4: A read of address 0x10 returns the oldest stored result, with the converter's 12-bit code unchanged in bits [11:0] and zeros in bits [15:12]. Results come back in conversion order.
- R5: In one-pass operation (control word A bit 2 = 0), one scan or external trigger converts every queued descriptor once, in write order, and consumes each one. A trigger while the descriptor queue is empty starts nothing.
- R6: In continuous operation (control word A bit 2 = 1), descriptors are not consumed. Each trigger converts as many descriptors as are queued, continuing from where the last pass stopped and wrapping from the last descriptor to the first.
- R7: With control word A bits [1:0] = 3, bit 3 = 0 makes a rising edge of ext_trig_i the trigger, and bit 3 = 1 makes a falling edge the trigger. The other edge starts nothing.
- R8: With control word A bits [1:0] = 2, a high cycle of scan_tick_i is the trigger, and ext_trig_i edges start nothing.
- R9: Control word B bit 9 enables the descriptor queue and bit 10 enables the result queue. While a bit is clear, its queue is empty and ignores writes and pushes.
- R10: Status bit 2 flags an empty result queue, bit 3 flags at least half of its depth filled, bit 4 flags it full, and bit 1 flags a full descriptor queue. Bit 0 is high while a conversion sequence is in progress.
- R11: A result arriving at a full result queue is dropped and sets the sticky status bit 5. That bit stays set through reads and clears only when control word B bit 10 is cleared.
- R12: The result queue reaching half full sets pending status bit 8 if control word A bit 8 is set. An accepted external trigger sets pending bit 9 if control word A bit 9 is set. irq_o is high when control word A bit 15 is set and any pending bit is set. Any write to address 0x04 clears the pending bits.
- R13: Writing start mode 0 aborts a running sequence, so no result is stored and no descriptor is consumed. Triggers that arrive while a sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte address (0x00, 0x02, 0x04, 0x10) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid from the cycle after the read strobe |
| scan_tick_i | input | 1 | Scan trigger pulse |
| ext_trig_i | input | 1 | External trigger level, synchronous to clk |
| conv_start_o | output | 1 | One-cycle start request to the converter |
| mux_sel_o | output | 4 | Analog channel select |
| gain_o | output | 2 | Gain step select |
| unipolar_o | output | 1 | Unipolar input range |
| diff_o | output | 1 | Differential input |
| conv_done_i | input | 1 | Converter done pulse, code valid with it |
| conv_code_i | input | 12 | Converter output code |
| irq_o | output | 1 | Interrupt request |

## Verification
The sequencer is driven with software-started single conversions, with scan-tick passes over descriptor queues of random length and content, and with continuous external-trigger passes on both edge polarities. Random lengths show whether the pass length follows the queue count. Repeating a continuous pass shows whether the descriptors survive and wrap, and the unused edge and the unused trigger source show whether each mode listens only to its own source. Directed runs fill the result queue past full to separate dropping from overwriting, abort a conversion in flight, and send a second start while busy, each followed by a conversion that shows whether a descriptor was lost.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned BUS_DW = 16;

  // Byte addresses of the register window
  localparam int unsigned OFS_CTLA = 'h00;  // write: control A, read: start
  localparam int unsigned OFS_CTLB = 'h02;  // write: control B
  localparam int unsigned OFS_STAT = 'h04;  // read: status, write: clear pending
  localparam int unsigned OFS_DATA = 'h10;  // write: descriptor, read: result

  // Control word A fields
  localparam int unsigned CA_CONT  = 2;
  localparam int unsigned CA_FALL  = 3;
  localparam int unsigned CA_HF_IE = 8;
  localparam int unsigned CA_EX_IE = 9;
  localparam int unsigned CA_GIE   = 15;

  // Control word B fields
  localparam int unsigned CB_LIST_EN = 9;
  localparam int unsigned CB_RES_EN  = 10;

  typedef enum logic [1:0] {
    TRG_OFF  = 2'd0,
    TRG_SOFT = 2'd1,
    TRG_SCAN = 2'd2,
    TRG_EXT  = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic       diff;
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] chan;
  } list_entry_t;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_STAT = 2'd1,
    RK_RES  = 2'd2
  } rd_kind_e;

endpackage

// File: rtl/adc_chan_list.sv
// Descriptor queue. One-pass mode pops the head; keep mode walks a cursor
// over the stored entries and wraps it. DEPTH must be a power of two.
module adc_chan_list #(
  parameter int DEPTH = 16,
  parameter int EW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [EW-1:0] din,
  input  logic          adv,
  input  logic          keep,
  output logic [EW-1:0] entry,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, base, cursor, idx;
  logic          push_ok, pop_ok, step_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !clr && !full;
  assign pop_ok  = adv && !clr && !keep && (count != '0);
  assign step_ok = adv && !clr && keep && (count != '0);
  assign idx     = keep ? (base + cursor) : base;
  assign entry   = mem[idx];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      base   <= '0;
      cursor <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + PW'(1);
      if (pop_ok)  base   <= base + PW'(1);
      if (!keep) begin
        cursor <= '0;
      end else if (step_ok) begin
        cursor <= ((CW'(cursor) + CW'(1)) == count) ? '0 : cursor + PW'(1);
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/adc_res_fifo.sv
// Result queue with a registered read port, so that block RAM can be used.
module adc_res_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !clr && !full;
  assign pop_ok  = pop && !clr && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (pop_ok) begin
      dout <= mem[rd_ptr];
    end else if (pop) begin
      dout <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + PW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + PW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: launches one conversion per descriptor and pushes
// each code when the converter answers.
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CW = 5,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          one_shot,
  input  logic          abort,
  input  logic [CW-1:0] list_cnt,
  input  list_entry_t   entry,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_code,
  output logic          conv_start,
  output list_entry_t   sel,
  output logic          adv,
  output logic          res_push,
  output logic [DW-1:0] res_data,
  output logic          busy
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_NEXT} seq_state_e;

  seq_state_e    state;
  logic [CW-1:0] left;
  logic          finish;

  assign finish   = (state == S_WAIT) && conv_done && !abort;
  assign adv      = finish;
  assign res_push = finish;
  assign res_data = conv_code;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      left       <= '0;
      conv_start <= 1'b0;
      sel        <= '0;
    end else begin
      conv_start <= 1'b0;
      if (abort) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (trig && list_cnt != '0) begin
            sel        <= entry;
            conv_start <= 1'b1;
            left       <= one_shot ? CW'(1) : list_cnt;
            state      <= S_WAIT;
          end
          S_WAIT: if (conv_done) begin
            if (left > CW'(1)) begin
              left  <= left - CW'(1);
              state <= S_NEXT;
            end else begin
              state <= S_IDLE;
            end
          end
          S_NEXT: if (list_cnt != '0) begin
            sel        <= entry;
            conv_start <= 1'b1;
            state      <= S_WAIT;
          end else begin
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 16,
  parameter int CODE_W     = 12,
  parameter int BUS_AW     = 5,
  localparam int LCW       = $clog2(LIST_DEPTH + 1),
  localparam int RCW       = $clog2(RES_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              scan_tick_i,
  input  logic              ext_trig_i,
  output logic              conv_start_o,
  output logic [3:0]        mux_sel_o,
  output logic [1:0]        gain_o,
  output logic              unipolar_o,
  output logic              diff_o,
  input  logic              conv_done_i,
  input  logic [CODE_W-1:0] conv_code_i,
  output logic              irq_o
);

  localparam logic [BUS_AW-1:0] A_CTLA = BUS_AW'(OFS_CTLA);
  localparam logic [BUS_AW-1:0] A_CTLB = BUS_AW'(OFS_CTLB);
  localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(OFS_STAT);
  localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(OFS_DATA);

  // Control state
  trig_mode_e mode_q;
  logic cont_q, fall_q, hf_ie_q, ex_ie_q, gie_q;
  logic list_en_q, res_en_q;

  // Datapath links
  logic [7:0]        list_entry;
  logic [LCW-1:0]    list_cnt;
  logic              list_full, list_push, list_adv;
  logic [CODE_W-1:0] res_dout, res_din;
  logic [RCW-1:0]    res_cnt;
  logic              res_empty, res_full, res_half, res_pop, seq_push, res_push;
  list_entry_t       seq_sel;
  logic              seq_busy, trig, abort;

  // Events, status, read path
  logic        ext_q, ext_fire, sw_fire, scan_fire, hf_q, irq_clr, ovf_q;
  logic [1:0]  pend;
  logic [BUS_DW-1:0] stat, stat_q;
  rd_kind_e    rkind_q;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata[14:11];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= TRG_OFF;
      cont_q    <= 1'b0;
      fall_q    <= 1'b0;
      hf_ie_q   <= 1'b0;
      ex_ie_q   <= 1'b0;
      gie_q     <= 1'b0;
      list_en_q <= 1'b0;
      res_en_q  <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTLA) begin
        mode_q  <= trig_mode_e'(bus_wdata[1:0]);
        cont_q  <= bus_wdata[CA_CONT];
        fall_q  <= bus_wdata[CA_FALL];
        hf_ie_q <= bus_wdata[CA_HF_IE];
        ex_ie_q <= bus_wdata[CA_EX_IE];
        gie_q   <= bus_wdata[CA_GIE];
      end
      if (bus_addr == A_CTLB) begin
        list_en_q <= bus_wdata[CB_LIST_EN];
        res_en_q  <= bus_wdata[CB_RES_EN];
      end
    end
  end

  // Trigger sources
  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_trig_i;
  end

  assign sw_fire   = bus_rd && (bus_addr == A_CTLA) && (mode_q == TRG_SOFT);
  assign scan_fire = scan_tick_i && (mode_q == TRG_SCAN);
  assign ext_fire  = (mode_q == TRG_EXT) &&
                     (fall_q ? (ext_q && !ext_trig_i) : (!ext_q && ext_trig_i));
  assign trig      = sw_fire || scan_fire || ext_fire;
  assign abort     = (mode_q == TRG_OFF) || !list_en_q;

  assign list_push = bus_wr && (bus_addr == A_DATA) && list_en_q;
  assign res_pop   = bus_rd && (bus_addr == A_DATA);
  assign res_push  = seq_push && res_en_q;

  adc_chan_list #(.DEPTH(LIST_DEPTH), .EW(8)) u_list (
    .clk   (clk),
    .rst   (rst),
    .clr   (!list_en_q),
    .push  (list_push),
    .din   (bus_wdata[7:0]),
    .adv   (list_adv),
    .keep  (cont_q),
    .entry (list_entry),
    .count (list_cnt),
    .full  (list_full)
  );

  adc_conv_seq #(.CW(LCW), .DW(CODE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .one_shot   (mode_q == TRG_SOFT),
    .abort      (abort),
    .list_cnt   (list_cnt),
    .entry      (list_entry_t'(list_entry)),
    .conv_done  (conv_done_i),
    .conv_code  (conv_code_i),
    .conv_start (conv_start_o),
    .sel        (seq_sel),
    .adv        (list_adv),
    .res_push   (seq_push),
    .res_data   (res_din),
    .busy       (seq_busy)
  );

  adc_res_fifo #(.DEPTH(RES_DEPTH), .W(CODE_W)) u_res (
    .clk   (clk),
    .rst   (rst),
    .clr   (!res_en_q),
    .push  (res_push),
    .din   (res_din),
    .pop   (res_pop),
    .dout  (res_dout),
    .count (res_cnt),
    .empty (res_empty),
    .full  (res_full)
  );

  assign mux_sel_o  = seq_sel.chan;
  assign gain_o     = seq_sel.gain;
  assign unipolar_o = seq_sel.unipolar;
  assign diff_o     = seq_sel.diff;

  assign res_half = (res_cnt >= RCW'(RES_DEPTH / 2));
  assign irq_clr  = bus_wr && (bus_addr == A_STAT);

  // Overflow flag and pending events
  always_ff @(posedge clk) begin
    if (rst || !res_en_q)               ovf_q <= 1'b0;
    else if (res_push && res_full)      ovf_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hf_q  <= 1'b0;
      pend  <= '0;
      irq_o <= 1'b0;
    end else begin
      hf_q  <= res_half;
      irq_o <= gie_q && (pend != '0);
      if (irq_clr) begin
        pend <= '0;
      end else begin
        if (res_half && !hf_q && hf_ie_q) pend[0] <= 1'b1;
        if (ext_fire && ex_ie_q)          pend[1] <= 1'b1;
      end
    end
  end

  always_comb begin
    stat      = '0;
    stat[0]   = seq_busy;
    stat[1]   = list_full;
    stat[2]   = res_empty;
    stat[3]   = res_half;
    stat[4]   = res_full;
    stat[5]   = ovf_q;
    stat[8]   = pend[0];
    stat[9]   = pend[1];
  end

  // Read path: one cycle of latency, held until the next read
  always_ff @(posedge clk) begin
    if (rst) begin
      rkind_q <= RK_NONE;
      stat_q  <= '0;
    end else if (bus_rd) begin
      stat_q <= stat;
      if (bus_addr == A_STAT)      rkind_q <= RK_STAT;
      else if (bus_addr == A_DATA) rkind_q <= RK_RES;
      else                         rkind_q <= RK_NONE;
    end
  end

  always_comb begin
    case (rkind_q)
      RK_STAT: bus_rdata = stat_q;
      RK_RES:  bus_rdata = BUS_DW'(res_dout);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_start,
  input logic [7:0] sel,
  input logic       ovf,
  input logic       res_en,
  input logic       res_full,
  input logic       res_empty,
  input logic       irq_clr,
  input logic [1:0] pend
);

  // R3: the converter start request lasts one cycle
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R2: front-end selects move only together with a start request
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (rst)
    $changed(sel) |-> conv_start);

  // R11: the overflow flag only drops when the result queue is disabled
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && res_en) |=> (ovf || !res_en));

  // R10: full and empty never coexist
  a_r10_full_empty: assert property (@(posedge clk) disable iff (rst)
    !(res_full && res_empty));

  // R12: a clear write leaves no pending event
  a_r12_pend_clear: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> (pend == 2'b00));

endmodule

bind adc_seq_top adc_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_start (conv_start_o),
  .sel        (seq_sel),
  .ovf        (ovf_q),
  .res_en     (res_en_q),
  .res_full   (res_full),
  .res_empty  (res_empty),
  .irq_clr    (irq_clr),
  .pend       (pend)
);

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;

  localparam logic [4:0] A_CTLA = 5'h00;
  localparam logic [4:0] A_CTLB = 5'h02;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_DATA = 5'h10;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        scan_tick, ext_trig;
  logic        conv_start, unipolar, diff, conv_done, irq;
  logic [3:0]  mux_sel;
  logic [1:0]  gain;
  logic [11:0] conv_code;

  always #2 clk = ~clk;  // 250 MHz

  adc_seq_top u0 (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .scan_tick_i  (scan_tick),
    .ext_trig_i   (ext_trig),
    .conv_start_o (conv_start),
    .mux_sel_o    (mux_sel),
    .gain_o       (gain),
    .unipolar_o   (unipolar),
    .diff_o       (diff),
    .conv_done_i  (conv_done),
    .conv_code_i  (conv_code),
    .irq_o        (irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter model: answers three negedges after seeing a start request.
  // Code = {front-end selects seen, low 4 bits of the conversion number}.
  int         n_start = 0;
  int         cdown = 0;
  logic [7:0] obs [256];

  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (rst) begin
      cdown = 0;
    end else if (conv_start) begin
      obs[n_start[7:0]] = {diff, unipolar, gain, mux_sel};
      conv_code <= {diff, unipolar, gain, mux_sel, n_start[3:0]};
      n_start++;
      cdown = 3;
    end else if (cdown > 0) begin
      cdown--;
      if (cdown == 0) conv_done <= 1'b1;
    end
  end

  function automatic logic [15:0] exp_res(input logic [7:0] e, input int idx);
    return {4'h0, e, idx[3:0]};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(A_STAT, s);
      if (!s[0]) break;
    end
  endtask

  task automatic pulse_scan();
    @(negedge clk); scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
  endtask

  task automatic set_ext(input logic v);
    @(negedge clk); ext_trig = v;
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] d;
  logic [7:0]  ent [16];
  int          base, len;

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    scan_tick = 0; ext_trig = 0; conv_done = 0; conv_code = '0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(A_STAT, d);
    chk(d == 16'h0004, "R1 status after reset", d, 16'h0004);
    chk({irq, conv_start, mux_sel, gain, unipolar, diff} == '0, "R1 outputs after reset",
        {irq, conv_start, mux_sel, gain, unipolar, diff}, 0);

    wr(A_CTLB, 16'h0600);

    // R2 R3 R4: software starts, one per read
    wr(A_CTLA, 16'h0001);
    ent[0] = 8'hC5; ent[1] = 8'h3A; ent[2] = 8'($urandom);
    for (int k = 0; k < 3; k++) wr(A_DATA, {8'h00, ent[k]});
    base = n_start;
    for (int k = 0; k < 3; k++) begin
      rd(A_CTLA, d);
      wait_idle();
      chk(n_start == base + k + 1, "R3 one conversion per start read", n_start, base + k + 1);
      chk(obs[8'(base + k)] == ent[k], "R2 front-end selects", obs[8'(base + k)], ent[k]);
    end
    for (int k = 0; k < 3; k++) begin
      rd(A_DATA, d);
      chk(d == exp_res(ent[k], base + k), "R4 result code and order", d, exp_res(ent[k], base + k));
    end
    rd(A_STAT, d);
    chk(d == 16'h0004, "R10 empty after drain", d, 16'h0004);

    // R3: start read outside software mode; R8: ext edge in scan mode
    wr(A_CTLA, 16'h0002);
    ent[0] = 8'($urandom);
    wr(A_DATA, {8'h00, ent[0]});
    base = n_start;
    rd(A_CTLA, d);
    set_ext(1'b1); set_ext(1'b0);
    idle_cycles(10);
    chk(n_start == base, "R3 R8 no start from read or ext in scan mode", n_start, base);

    // R5 R8: scan passes with random queue length and content
    for (int k = 1; k < 4; k++) begin
      ent[k] = 8'($urandom);
      wr(A_DATA, {8'h00, ent[k]});
    end
    len = 4;
    for (int it = 0; it < 7; it++) begin
      if (it > 0) begin
        len = 1 + $urandom_range(0, 6);
        for (int k = 0; k < len; k++) begin
          ent[k] = 8'($urandom);
          wr(A_DATA, {8'h00, ent[k]});
        end
      end
      base = n_start;
      pulse_scan();
      wait_idle();
      chk(n_start == base + len, "R5 R8 scan converts every entry", n_start, base + len);
      for (int k = 0; k < len; k++)
        chk(obs[8'(base + k)] == ent[k], "R5 scan order", obs[8'(base + k)], ent[k]);
      for (int k = 0; k < len; k++) begin
        rd(A_DATA, d);
        chk(d == exp_res(ent[k], base + k), "R4 scan results", d, exp_res(ent[k], base + k));
      end
    end
    base = n_start;
    pulse_scan();
    idle_cycles(10);
    chk(n_start == base, "R5 trigger with empty queue", n_start, base);

    // R6 R7 R12: continuous external trigger, both polarities
    wr(A_CTLA, 16'h0207);
    for (int k = 0; k < 3; k++) begin
      ent[k] = 8'($urandom);
      wr(A_DATA, {8'h00, ent[k]});
    end
    base = n_start;
    set_ext(1'b1);
    wait_idle();
    chk(n_start == base + 3, "R7 rising edge pass", n_start, base + 3);
    rd(A_STAT, d);
    chk(d[9] == 1'b1, "R12 ext pending bit", d[9], 1);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, d);
    chk(d[9] == 1'b0, "R12 pending cleared", d[9], 0);
    set_ext(1'b0);
    idle_cycles(10);
    chk(n_start == base + 3, "R7 falling edge ignored in rising mode", n_start, base + 3);
    set_ext(1'b1);
    wait_idle();
    chk(n_start == base + 6, "R6 second pass length", n_start, base + 6);
    for (int k = 0; k < 3; k++)
      chk(obs[8'(base + 3 + k)] == ent[k], "R6 entries kept and wrapped", obs[8'(base + 3 + k)], ent[k]);
    wr(A_CTLA, 16'h020F);
    set_ext(1'b0);
    wait_idle();
    chk(n_start == base + 9, "R7 falling edge pass", n_start, base + 9);
    set_ext(1'b1);
    idle_cycles(10);
    chk(n_start == base + 9, "R7 rising edge ignored in falling mode", n_start, base + 9);
    rd(A_DATA, d);
    chk(d == exp_res(ent[0], base), "R4 continuous first result", d, exp_res(ent[0], base));

    // R9: disabling the result queue empties it
    wr(A_STAT, 16'h0000);
    wr(A_CTLB, 16'h0200);
    rd(A_STAT, d);
    chk(d == 16'h0004, "R9 result queue cleared", d, 16'h0004);

    // R9: disabling the descriptor queue empties it, writes then ignored
    wr(A_CTLB, 16'h0400);
    wr(A_CTLB, 16'h0600);
    wr(A_CTLA, 16'h0001);
    base = n_start;
    rd(A_CTLA, d);
    idle_cycles(10);
    chk(n_start == base, "R9 descriptor queue cleared", n_start, base);
    wr(A_CTLB, 16'h0400);
    wr(A_DATA, 16'h0011);
    wr(A_CTLB, 16'h0600);
    rd(A_CTLA, d);
    idle_cycles(10);
    chk(n_start == base, "R9 write while disabled ignored", n_start, base);

    // R10 R11 R12: fill the result queue past full
    wr(A_CTLA, 16'h8105);
    ent[0] = 8'($urandom);
    wr(A_DATA, {8'h00, ent[0]});
    base = n_start;
    for (int i = 1; i <= 17; i++) begin
      rd(A_CTLA, d);
      wait_idle();
      if (i == 7) begin
        rd(A_STAT, d);
        chk(d == 16'h0000, "R10 below half", d, 16'h0000);
        chk(irq == 1'b0, "R12 no irq below half", irq, 0);
      end
      if (i == 8) begin
        rd(A_STAT, d);
        chk(d == 16'h0108, "R10 R12 half full and pending", d, 16'h0108);
        chk(irq == 1'b1, "R12 irq raised", irq, 1);
      end
      if (i == 16) begin
        rd(A_STAT, d);
        chk(d == 16'h0118, "R10 full", d, 16'h0118);
      end
    end
    rd(A_STAT, d);
    chk(d == 16'h0138, "R11 overflow flag", d, 16'h0138);
    wr(A_STAT, 16'h0000);
    idle_cycles(2);
    chk(irq == 1'b0, "R12 irq cleared", irq, 0);
    rd(A_DATA, d);
    chk(d == exp_res(ent[0], base), "R11 oldest result kept", d, exp_res(ent[0], base));
    rd(A_STAT, d);
    chk(d == 16'h0028, "R11 overflow sticky after read", d, 16'h0028);
    wr(A_CTLB, 16'h0200);
    wr(A_CTLB, 16'h0600);
    rd(A_STAT, d);
    chk(d == 16'h0004, "R11 overflow cleared by disable", d, 16'h0004);

    // R10: descriptor queue full flag
    for (int k = 0; k < 15; k++) wr(A_DATA, {8'h00, 8'($urandom)});
    rd(A_STAT, d);
    chk(d == 16'h0006, "R10 descriptor queue full", d, 16'h0006);

    // R13: abort in flight, then a start while busy
    wr(A_CTLB, 16'h0400);
    wr(A_CTLB, 16'h0600);
    wr(A_CTLA, 16'h0001);
    ent[0] = 8'($urandom); ent[1] = 8'($urandom);
    wr(A_DATA, {8'h00, ent[0]});
    wr(A_DATA, {8'h00, ent[1]});
    base = n_start;
    rd(A_CTLA, d);
    wr(A_CTLA, 16'h0000);
    idle_cycles(12);
    rd(A_STAT, d);
    chk(d == 16'h0004, "R13 abort stores nothing", d, 16'h0004);
    wr(A_CTLA, 16'h0001);
    rd(A_CTLA, d);
    rd(A_CTLA, d);
    wait_idle();
    chk(n_start == base + 2, "R13 start while busy ignored", n_start, base + 2);
    chk(obs[8'(base + 1)] == ent[0], "R13 aborted entry not consumed", obs[8'(base + 1)], ent[0]);
    rd(A_CTLA, d);
    wait_idle();
    chk(obs[8'(base + 2)] == ent[1], "R13 ignored start consumed nothing", obs[8'(base + 2)], ent[1]);
    rd(A_DATA, d);
    chk(d == exp_res(ent[0], base + 1), "R13 result after abort", d, exp_res(ent[0], base + 1));
    rd(A_DATA, d);
    chk(d == exp_res(ent[1], base + 2), "R13 next result", d, exp_res(ent[1], base + 2));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule